// File: doc/BRIEF.md
# Serial DDS Frequency Programmer

This block is the host-side controller that loads a frequency tuning word into a direct digital synthesizer over three wires: a serial data pin, a write clock and a frequency-update strobe. On a start request it latches a 32-bit tuning word and an 8-bit control byte. It then shifts out a 40-bit frame: the tuning word least-significant bit first, followed by the control byte, also least-significant bit first. It finishes with an update strobe that commits the new word inside the synthesizer.

After reset, the synthesizer must be placed in serial loading mode before it accepts a frame. The controller does this once, in front of the first frame: one write-clock pulse, then one update-strobe pulse. A dedicated re-initialisation input requests the same entry sequence again in front of the next frame. Every write-clock and strobe phase lasts a programmable number of system clocks, so the pin rate can match slow wiring. The tuning word is supplied directly; no frequency arithmetic is performed.

Top module: `dds_serial_prog`

## Requirements
- R1: While reset is held and right after it, wclk_o, fqud_o, sdata_o, busy_o and done_o are all low.
- R2: A frame is 40 bits, taken on rising edges of wclk_o: tune_word_i bits 0 through 31 first, then ctrl_byte_i bits 0 through 7.
- R3: sdata_o changes only while wclk_o is low and holds its value for as long as wclk_o is high.
- R4: After the 40th rising edge of wclk_o, fqud_o goes high for exactly one half-period while wclk_o is low, and then returns low.
- R5: The first transfer after reset starts with the entry sequence: one wclk_o pulse with sdata_o low, then one fqud_o pulse, each phase one half-period long.
- R6: The entry sequence is sent only once after reset; a pulse on reinit_i makes the next transfer send it again.
- R7: Each half-period lasts half_div_i system clocks, with 0 treated as 1. A transfer keeps busy_o high for 81 half-periods, or 84 when it includes the entry sequence.
- R8: busy_o rises in the cycle after start_i is sampled and falls when the update strobe ends. done_o is high for exactly one cycle, the cycle in which busy_o has just fallen.
- R9: A start_i pulse while busy_o is high is ignored: no extra frame or strobe follows.
- R10: The tuning word, the control byte and half_div_i are latched when a transfer starts. Changes to them during the transfer do not alter the frame or its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a transfer when idle |
| reinit_i | input | 1 | Request the serial-mode entry sequence before the next frame |
| tune_word_i | input | 32 | Frequency tuning word |
| ctrl_byte_i | input | 8 | Control bits sent after the tuning word |
| half_div_i | input | 8 | Half-period length in system clocks (0 acts as 1) |
| wclk_o | output | 1 | Serial write clock to the synthesizer |
| fqud_o | output | 1 | Frequency-update strobe |
| sdata_o | output | 1 | Serial data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The bench decodes the pins the way the synthesizer would. It collects one bit on each write-clock rise and closes a frame on each strobe rise. A bit-order or frame-length mistake therefore shows up as a wrong 40-bit word or a strobe after the wrong number of clocks. It checks a divider of zero and a divider above one. A divider that counted off by one, or treated zero as a huge count, would stretch busy past 81 or 84 half-periods. It repeats the entry sequence after a re-initialisation request and omits it otherwise. A controller that forgot the flag would add or drop the extra single-bit strobe. Finally, it changes the inputs and pulses start in the middle of a transfer. A design that did not latch its inputs would send a mixed word, and one that accepted the second start would emit a second strobe.

// File: rtl/dds_prog_pkg.sv
package dds_prog_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned FRAME_W = WORD_W + CTRL_W;
  localparam int unsigned BCNT_W  = $clog2(FRAME_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT_CLK,
    ST_INIT_GAP,
    ST_INIT_FQ,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_UPDATE
  } prog_state_e;
endpackage

// File: rtl/dds_half_timer.sv
module dds_half_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == limit_i - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: the count never runs past the half-period length
  a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/dds_frame_shreg.sv
module dds_frame_shreg
  import dds_prog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               bit_o,
  output logic               last_o
);
  localparam logic [BCNT_W-1:0] LAST_IDX = BCNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [BCNT_W-1:0]  idx_q, idx_d;

  always_comb begin
    sr_d  = sr_q;
    idx_d = idx_q;
    if (load_i) begin
      sr_d  = frame_i;
      idx_d = '0;
    end else if (shift_i) begin
      sr_d  = {1'b0, sr_q[FRAME_W-1:1]};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else begin
      sr_q  <= sr_d;
      idx_q <= idx_d;
    end
  end

  assign bit_o  = sr_q[0];
  assign last_o = (idx_q == LAST_IDX);

  // R2: the bit index stays inside the 40-bit frame
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);
  // R2: no shift is requested once the final bit has gone out
  a_r2_no_overshift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |-> !last_o);
endmodule

// File: rtl/dds_serial_prog.sv
module dds_serial_prog
  import dds_prog_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             reinit_i,
  input  logic [31:0]      tune_word_i,
  input  logic [7:0]       ctrl_byte_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             wclk_o,
  output logic             fqud_o,
  output logic             sdata_o,
  output logic             busy_o,
  output logic             done_o
);
  prog_state_e      state_q, state_d;
  logic             need_init_q, need_init_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             tick, accept, shift, last_bit, sr_bit;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign shift  = (state_q == ST_BIT_HI) && tick && !last_bit;

  dds_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (state_q != ST_IDLE),
    .limit_i (div_q),
    .tick_o  (tick)
  );

  dds_frame_shreg u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .shift_i (shift),
    .frame_i ({ctrl_byte_i, tune_word_i}),
    .bit_o   (sr_bit),
    .last_o  (last_bit)
  );

  always_comb begin
    state_d     = state_q;
    need_init_d = need_init_q;
    done_d      = 1'b0;
    div_d       = div_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        div_d   = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
        state_d = need_init_q ? ST_INIT_CLK : ST_BIT_LO;
      end
      ST_INIT_CLK: if (tick) state_d = ST_INIT_GAP;
      ST_INIT_GAP: if (tick) state_d = ST_INIT_FQ;
      ST_INIT_FQ: if (tick) begin
        state_d     = ST_BIT_LO;
        need_init_d = 1'b0;
      end
      ST_BIT_LO: if (tick) state_d = ST_BIT_HI;
      ST_BIT_HI: if (tick) state_d = last_bit ? ST_UPDATE : ST_BIT_LO;
      ST_UPDATE: if (tick) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (reinit_i) need_init_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      need_init_q <= 1'b1;
      done_q      <= 1'b0;
      div_q       <= DIV_W'(1);
    end else begin
      state_q     <= state_d;
      need_init_q <= need_init_d;
      done_q      <= done_d;
      div_q       <= div_d;
    end
  end

  assign wclk_o  = (state_q == ST_INIT_CLK) || (state_q == ST_BIT_HI);
  assign fqud_o  = (state_q == ST_INIT_FQ)  || (state_q == ST_UPDATE);
  assign sdata_o = ((state_q == ST_BIT_LO) || (state_q == ST_BIT_HI)) && sr_bit;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  // R4: strobe and write clock are never high together
  a_r4_fq_wclk_excl: assert property (@(posedge clk) disable iff (!rst_n)
    fqud_o |-> !wclk_o);
  // R3: data holds while the write clock stays high
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wclk_o && $past(wclk_o)) |-> $stable(sdata_o));
  // R8: done is a single-cycle pulse, seen only once idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $fell(busy_o)));
  // R10: the latched divider is held for the whole transfer
  a_r10_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(div_q));
endmodule

// File: tb/sim_dds_serial_prog.sv
module sim_dds_serial_prog;
  logic        clk, rst_n, start_i, reinit_i;
  logic [31:0] tune_word_i;
  logic [7:0]  ctrl_byte_i, half_div_i;
  logic        wclk_o, fqud_o, sdata_o, busy_o, done_o;

  int checks = 0, failures = 0;

  dds_serial_prog u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reinit_i(reinit_i),
    .tune_word_i(tune_word_i), .ctrl_byte_i(ctrl_byte_i), .half_div_i(half_div_i),
    .wclk_o(wclk_o), .fqud_o(fqud_o), .sdata_o(sdata_o), .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // pin decoder, sampled on the falling edge
  logic [39:0] shw, last_word;
  int nb, last_bits, init_seen, fq_rises, fq_len, fq_width, busy_cyc, done_cyc, stab_err;
  logic pw, pf, pd;

  always @(negedge clk) begin
    if (!rst_n) begin
      pw = 0; pf = 0; pd = 0;
    end else begin
      if (wclk_o && pw && (sdata_o !== pd)) stab_err++;
      if (wclk_o && !pw) begin shw = {sdata_o, shw[39:1]}; nb++; end
      if (fqud_o && !pf) begin
        fq_rises++;
        if (nb == 1) init_seen++;
        else begin last_bits = nb; last_word = shw; end
        nb = 0; fq_len = 0;
      end
      if (fqud_o) fq_len++;
      if (!fqud_o && pf) fq_width = fq_len;
      if (busy_o) busy_cyc++;
      if (done_o) begin
        done_cyc++;
        if (busy_o) stab_err++;
      end
      pw = wclk_o; pf = fqud_o; pd = sdata_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    nb = 0; last_bits = 0; last_word = '0; init_seen = 0; fq_rises = 0;
    fq_width = 0; busy_cyc = 0; done_cyc = 0; stab_err = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done_o && t < 5000) begin @(negedge clk); t++; end
    if (t >= 5000) chk(0, "R8", "watchdog timeout", t, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic kick(input logic [31:0] w, input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    clear_mon();
    tune_word_i = w; ctrl_byte_i = c; half_div_i = d; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic frame_checks(input string tag, input logic [31:0] w,
                              input logic [7:0] c, input int n, input bit with_init);
    chk(last_bits == 40, "R2", {tag, " bit count"}, last_bits, 40);
    chk(last_word == {c, w}, "R2", {tag, " frame word"}, last_word, {c, w});
    chk(stab_err == 0, "R3", {tag, " data stable while wclk high"}, stab_err, 0);
    chk(fq_width == n, "R4", {tag, " strobe width"}, fq_width, n);
    chk(init_seen == (with_init ? 1 : 0), "R5", {tag, " entry sequence"}, init_seen, with_init);
    chk(busy_cyc == (with_init ? 84 : 81) * n, "R7", {tag, " busy length"},
        busy_cyc, (with_init ? 84 : 81) * n);
    chk(done_cyc == 1, "R8", {tag, " done pulses"}, done_cyc, 1);
  endtask

  task automatic t_reset();
    chk({wclk_o, fqud_o, sdata_o, busy_o, done_o} == 5'b0, "R1", "outputs after reset",
        {wclk_o, fqud_o, sdata_o, busy_o, done_o}, 0);
  endtask

  task automatic t_first_frame();
    kick(32'h0003_9E0F, 8'h00, 8'd1);
    chk(busy_o == 1, "R8", "busy after start", busy_o, 1);
    wait_done();
    frame_checks("first", 32'h0003_9E0F, 8'h00, 1, 1);
  endtask

  task automatic t_div3_no_init();
    kick(32'hA5C3_1E78, 8'h96, 8'd3);
    wait_done();
    frame_checks("div3", 32'hA5C3_1E78, 8'h96, 3, 0);
  endtask

  task automatic t_div0();
    kick(32'h8000_0001, 8'h81, 8'd0);
    wait_done();
    frame_checks("div0", 32'h8000_0001, 8'h81, 1, 0);
  endtask

  task automatic t_latch_and_ignore();
    kick(32'h1234_5678, 8'h3C, 8'd2);
    repeat (40) @(negedge clk);
    tune_word_i = 32'hFFFF_0000; ctrl_byte_i = 8'hFF; half_div_i = 8'd5;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    wait_done();
    repeat (20) @(negedge clk);
    chk(last_word == {8'h3C, 32'h1234_5678}, "R10", "word latched at start",
        last_word, {8'h3C, 32'h1234_5678});
    chk(busy_cyc == 162, "R10", "divider latched at start", busy_cyc, 162);
    chk(fq_rises == 1, "R9", "start while busy ignored", fq_rises, 1);
    chk(busy_o == 0, "R9", "idle after ignored start", busy_o, 0);
  endtask

  task automatic t_reinit();
    @(negedge clk);
    reinit_i = 1;
    @(negedge clk);
    reinit_i = 0;
    kick(32'hDEAD_BEEF, 8'h00, 8'd2);
    wait_done();
    frame_checks("reinit", 32'hDEAD_BEEF, 8'h00, 2, 1);
    chk(fq_rises == 2, "R6", "strobes with reinit", fq_rises, 2);
    kick(32'h0F0F_F0F0, 8'h00, 8'd1);
    wait_done();
    chk(init_seen == 0, "R6", "entry not repeated", init_seen, 0);
    chk(last_word == {8'h00, 32'h0F0F_F0F0}, "R2", "post-reinit word",
        last_word, {8'h00, 32'h0F0F_F0F0});
  endtask

  initial begin
    rst_n = 0; start_i = 0; reinit_i = 0;
    tune_word_i = '0; ctrl_byte_i = '0; half_div_i = 8'd1;
    clear_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_first_frame();
    t_div3_no_init();
    t_div0();
    t_latch_and_ignore();
    t_reinit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule